// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Interface

This block is the peripheral side of an 8-bit bus that carries address and data on the same lines. A host first presents a register address and marks it with an address strobe. It then moves one data byte in a data-transfer phase that is qualified by chip select. A strapped mode input selects one of two strobe protocols. In the dual-strobe protocol, the data-strobe pin acts as a read strobe and the read/write pin acts as a write strobe. In the level-qualified protocol, the data-strobe pin times the transfer and the read/write pin gives its direction.

All bus inputs are asynchronous to the block. They are resampled by a synchronizer on a fast system clock, and edges are found from the resampled values. Every decoded access appears on the register-file side as a one-cycle pulse together with a 7-bit address and, for writes, a data byte. For reads, the block enables the bus driver and returns the register file's combinational read data. Locations at or beyond the implemented register count read as zero, and writes to them are dropped.

Top module: `mxbus_if`

## Requirements
- R1: While `rst_n` is low, `reg_we`, `reg_re` and `ad_oe` stay 0 whatever the bus does, and `reg_addr` is 0.
- R2: A falling edge on `as_strb` loads `reg_addr` with `ad_in[6:0]` as sampled just before the fall. This happens whether `cs_n` is high or low.
- R3: With `bus_mode`=0 (dual-strobe), `cs_n` low and `ds_strb` high, a rising edge on `rw_strb` gives exactly one `reg_we` pulse within 4 clocks. `reg_wdata` then equals the `ad_in` byte held while `rw_strb` was low.
- R4: With `bus_mode`=0, `cs_n` low and `rw_strb` high, `ds_strb` low raises `ad_oe`. A falling edge of `ds_strb` gives one `reg_re` pulse. `ad_oe` drops after `ds_strb` returns high.
- R5: With `bus_mode`=1 (level-qualified), `cs_n` low and `rw_strb` high, `ds_strb` high raises `ad_oe`. A rising edge of `ds_strb` gives one `reg_re` pulse.
- R6: With `bus_mode`=1, `cs_n` low and `rw_strb` low, a falling edge on `ds_strb` gives exactly one `reg_we` pulse carrying the byte held while `ds_strb` was high.
- R7: With `cs_n` high, no strobe activity gives `reg_we` or `reg_re`, and `ad_oe` stays 0.
- R8: For an address at or above `IMPL_REGS` (default 114), a read drives `ad_out` to 0x00 with no `reg_re` pulse. A write gives no `reg_we` pulse.
- R9: `ad_oe` is 0 throughout a write cycle in either mode.
- R10: While `ad_oe` is 1 and the address is in range, `ad_out` equals `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_mode | input | 1 | 0 dual-strobe timing, 1 level-qualified timing |
| cs_n | input | 1 | Active-low chip select |
| as_strb | input | 1 | Address strobe, address taken on its fall |
| ds_strb | input | 1 | Read strobe (mode 0) or data strobe (mode 1) |
| rw_strb | input | 1 | Write strobe (mode 0) or direction level (mode 1) |
| ad_in | input | 8 | Multiplexed address/data bus, received side |
| ad_out | output | 8 | Read data to the bus |
| ad_oe | output | 1 | Bus driver enable |
| reg_addr | output | 7 | Captured register address |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-cycle write pulse |
| reg_re | output | 1 | One-cycle read pulse |
| reg_rdata | input | 8 | Combinational read data from the register file |

## Verification
The bench latches an address while chip select is high and then reads with no new address phase. A design that gated address capture with chip select would return the previous location. It checks out-of-range reads and writes at the first unimplemented address. A design with an off-by-one limit, or one that only zeroed the data, would pulse a strobe there. The bench runs both protocols with the same pin waveforms and swapped meanings. A decoder that confused which edge qualifies a write would give two pulses or none, or would drive the bus during a write. Accesses are also issued while reset is held, where any pulse is an error.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    typedef enum logic {
        MODE_DUAL  = 1'b0,
        MODE_LEVEL = 1'b1
    } mode_e;

    // synchronized control pins
    typedef struct packed {
        logic as_s;
        logic ds_s;
        logic rw_s;
        logic cs_n_s;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // decoded bus events for one clock
    typedef struct packed {
        logic addr_cap;
        logic rd_go;
        logic wr_go;
        logic rd_win;
    } evt_t;

endpackage

// File: rtl/mxbus_sync.sv
module mxbus_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] stg_d;
        if (i == 0) begin : g_first
            assign stg_d = d;
        end else begin : g_next
            assign stg_d = stg_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mxbus_strobe_dec.sv
module mxbus_strobe_dec
    import mxbus_pkg::*;
(
    input  mode_e mode,
    input  ctl_t  cur,
    input  ctl_t  prv,
    output evt_t  evt
);

    logic sel, as_fall, ds_fall, ds_rise, rw_rise;

    always_comb begin
        // chip select must be low on both sides of the edge
        sel     = !cur.cs_n_s && !prv.cs_n_s;
        as_fall = prv.as_s && !cur.as_s;
        ds_fall = prv.ds_s && !cur.ds_s;
        ds_rise = !prv.ds_s && cur.ds_s;
        rw_rise = !prv.rw_s && cur.rw_s;

        evt          = '0;
        evt.addr_cap = as_fall;
        if (mode == MODE_LEVEL) begin
            evt.rd_go  = sel && ds_rise && cur.rw_s;
            evt.wr_go  = sel && ds_fall && !prv.rw_s;
            evt.rd_win = !cur.cs_n_s && cur.ds_s && cur.rw_s;
        end else begin
            evt.rd_go  = sel && ds_fall && cur.rw_s;
            evt.wr_go  = sel && rw_rise && cur.ds_s;
            evt.rd_win = !cur.cs_n_s && !cur.ds_s && cur.rw_s;
        end
    end

endmodule

// File: rtl/mxbus_if.sv
module mxbus_if
    import mxbus_pkg::*;
#(
    parameter int AW          = 7,
    parameter int DW          = 8,
    parameter int IMPL_REGS   = 114,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode,
    input  logic          cs_n,
    input  logic          as_strb,
    input  logic          ds_strb,
    input  logic          rw_strb,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);

    localparam int          SW    = CTL_W + DW;
    localparam logic [AW:0] LIMIT = (AW+1)'(IMPL_REGS);
    // idle: strobes and select high, bus zero
    localparam logic [SW-1:0] SYNC_RST = {{CTL_W{1'b1}}, {DW{1'b0}}};

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          we;
        logic          re;
        logic          oe;
        ctl_t          ctl;
        logic [DW-1:0] ad;
    } st_t;

    localparam st_t ST_RST = '{addr: '0, wdata: '0, we: 1'b0, re: 1'b0,
                               oe: 1'b0, ctl: '1, ad: '0};

    logic [SW-1:0] sync_q;
    ctl_t          ctl_cur;
    logic [DW-1:0] ad_cur;
    evt_t          evt;
    st_t           st_d, st_q;
    logic          hit_d, hit_q;

    mxbus_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({as_strb, ds_strb, rw_strb, cs_n, ad_in}),
        .q     (sync_q)
    );

    assign ctl_cur = ctl_t'(sync_q[SW-1:DW]);
    assign ad_cur  = sync_q[DW-1:0];

    mxbus_strobe_dec dec_i (
        .mode (mode_e'(bus_mode)),
        .cur  (ctl_cur),
        .prv  (st_q.ctl),
        .evt  (evt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ctl = ctl_cur;
        st_d.ad  = ad_cur;
        st_d.we  = 1'b0;
        st_d.re  = 1'b0;
        // bus byte one sample before the edge is the stable one
        if (evt.addr_cap) st_d.addr = st_q.ad[AW-1:0];
        hit_d    = {1'b0, st_d.addr} < LIMIT;
        if (evt.wr_go && hit_d) begin
            st_d.we    = 1'b1;
            st_d.wdata = st_q.ad;
        end
        st_d.re  = evt.rd_go && hit_d;
        st_d.oe  = evt.rd_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign hit_q     = {1'b0, st_q.addr} < LIMIT;
    assign ad_out    = (st_q.oe && hit_q) ? reg_rdata : '0;
    assign ad_oe     = st_q.oe;
    assign reg_addr  = st_q.addr;
    assign reg_wdata = st_q.wdata;
    assign reg_we    = st_q.we;
    assign reg_re    = st_q.re;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!reg_we && !reg_re && !ad_oe));

    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R7
    oe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(!ctl_cur.cs_n_s));

    // R8
    we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ({1'b0, reg_addr} < LIMIT));

    // R9
    we_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !ad_oe);

endmodule

// File: tb/mxbus_if_tb.sv
module mxbus_if_tb_top;

    localparam int IMPL = 114;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       as_strb = 1'b0;
    logic       ds_strb = 1'b1;
    logic       rw_strb = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out, reg_wdata, reg_rdata;
    logic [6:0] reg_addr;
    logic       ad_oe, reg_we, reg_re;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    logic [14:0] exp_q [$];

    always #4 clk = ~clk;

    assign reg_rdata = {1'b0, reg_addr} ^ 8'h5A;

    mxbus_if dut_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
        .as_strb(as_strb), .ds_strb(ds_strb), .rw_strb(rw_strb),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every write pulse
    always @(negedge clk) begin
        if (reg_we) begin
            we_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R6 unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                chk({reg_addr, reg_wdata} == e, "R3/R6 write item",
                    {reg_addr, reg_wdata}, e);
            end
        end
        if (reg_re) re_cnt++;
    end

    task automatic addr_phase(input logic [6:0] a);
        @(negedge clk);
        ad_in = {1'b0, a};
        as_strb = 1'b1;
        wait_n(4);
        as_strb = 1'b0;
        wait_n(4);
    endtask

    task automatic dual_wr(input logic [6:0] a, input logic [7:0] d,
                           input logic sel_n, input bit expect_we, input string tag);
        int c0;
        addr_phase(a);
        cs_n = sel_n; ad_in = d; rw_strb = 1'b0;
        wait_n(4);
        chk(ad_oe == 1'b0, "R9 dual write drive", ad_oe, 0);
        c0 = we_cnt;
        if (expect_we) exp_q.push_back({a, d});
        rw_strb = 1'b1;
        wait_n(4);
        chk((we_cnt - c0) == int'(expect_we), tag, we_cnt - c0, int'(expect_we));
        cs_n = 1'b1;
        wait_n(2);
    endtask

    task automatic dual_rd(input logic sel_n, input logic [6:0] a, input string tag);
        int c0;
        bit on, hit;
        logic [7:0] e;
        on  = !sel_n;
        hit = a < IMPL;
        e   = hit ? ({1'b0, a} ^ 8'h5A) : 8'h00;
        cs_n = sel_n;
        wait_n(2);
        c0 = re_cnt;
        ds_strb = 1'b0;
        wait_n(5);
        chk(ad_oe == on, {tag, " oe"}, ad_oe, on);
        if (on) chk(ad_out == e, {tag, " data"}, ad_out, e);
        chk((re_cnt - c0) == int'(on && hit), {tag, " re"}, re_cnt - c0, int'(on && hit));
        ds_strb = 1'b1;
        wait_n(5);
        chk(ad_oe == 1'b0, "R4 oe release", ad_oe, 0);
        cs_n = 1'b1;
        wait_n(2);
    endtask

    task automatic lvl_wr(input logic [6:0] a, input logic [7:0] d, input string tag);
        int c0;
        addr_phase(a);
        cs_n = 1'b0; rw_strb = 1'b0; ad_in = d;
        wait_n(2);
        ds_strb = 1'b1;
        wait_n(4);
        chk(ad_oe == 1'b0, "R9 level write drive", ad_oe, 0);
        c0 = we_cnt;
        if (a < IMPL) exp_q.push_back({a, d});
        ds_strb = 1'b0;
        wait_n(4);
        chk((we_cnt - c0) == int'(a < IMPL), tag, we_cnt - c0, int'(a < IMPL));
        rw_strb = 1'b1; cs_n = 1'b1;
        wait_n(2);
    endtask

    task automatic lvl_rd(input logic [6:0] a, input string tag);
        int c0;
        logic [7:0] e;
        e = (a < IMPL) ? ({1'b0, a} ^ 8'h5A) : 8'h00;
        addr_phase(a);
        cs_n = 1'b0; rw_strb = 1'b1;
        wait_n(2);
        c0 = re_cnt;
        ds_strb = 1'b1;
        wait_n(5);
        chk(ad_oe == 1'b1, {tag, " oe"}, ad_oe, 1);
        chk(ad_out == e, {tag, " data"}, ad_out, e);
        chk((re_cnt - c0) == int'(a < IMPL), {tag, " re"}, re_cnt - c0, int'(a < IMPL));
        ds_strb = 1'b0;
        wait_n(5);
        chk(ad_oe == 1'b0, "R5 oe release", ad_oe, 0);
        cs_n = 1'b1;
        wait_n(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: activity under reset is ignored
        wait_n(4);
        chk(reg_addr == 7'd0, "R1 reset addr", reg_addr, 0);
        dual_wr(7'd9, 8'h33, 1'b0, 1'b0, "R1 write in reset");
        cs_n = 1'b0; ds_strb = 1'b0;
        wait_n(5);
        chk(ad_oe == 1'b0 && re_cnt == 0, "R1 read in reset", ad_oe, 0);
        ds_strb = 1'b1; cs_n = 1'b1;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(6);

        // R3, dual-strobe writes
        dual_wr(7'd3,   8'hC4, 1'b0, 1'b1, "R3 write low");
        dual_wr(7'd113, 8'h0F, 1'b0, 1'b1, "R3 write last reg");
        // R7: deselected write
        dual_wr(7'd20,  8'h77, 1'b1, 1'b0, "R7 write deselected");
        // R8: first unimplemented address
        dual_wr(7'd114, 8'h11, 1'b0, 1'b0, "R8 write out of range");

        // R2: address latched with cs high, read without new address phase
        addr_phase(7'd5);
        chk(reg_addr == 7'd5, "R2 capture deselected", reg_addr, 5);
        dual_rd(1'b0, 7'd5, "R4 R10 read");
        addr_phase(7'd40);
        dual_rd(1'b1, 7'd40, "R7 read deselected");
        addr_phase(7'd127);
        dual_rd(1'b0, 7'd127, "R8 read out of range");

        // switch to level-qualified timing under reset
        rst_n = 1'b0; bus_mode = 1'b1; ds_strb = 1'b0; rw_strb = 1'b1;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(6);
        lvl_wr(7'd7,  8'hA9, "R6 write");
        lvl_wr(7'd64, 8'h5E, "R6 write mid");
        lvl_wr(7'd120, 8'hFF, "R8 level write out of range");
        lvl_rd(7'd7,  "R5 R10 read");
        lvl_rd(7'd114, "R8 level read out of range");

        chk(exp_q.size() == 0, "R3/R6 pending writes", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule